// File: doc/BRIEF.md
# Brown-out Reset and Power-up Sequencer

This block produces the chip-wide internal reset. It watches a raw "supply below threshold" flag from an analog comparator, brings it into the clock domain, and treats it as a brown-out only when it persists past a minimum qualification time. A two-bit mode field, a software enable bit and the sleep indicator decide whether brown-out detection is active. Detection can be permanently off, under software control, suspended while the device sleeps, or permanently on.

Reset is raised by power-on, by a watchdog request or by a qualified brown-out. It stays raised while the supply is low. After the supply recovers, an optional power-up delay keeps reset asserted for a fixed number of clock cycles. The nominal delay is 64 ms, and both the delay and the qualification time are parameters given in cycles. If the supply dips again while the delay runs, the sequencer returns to its holding phase and the full delay starts over after the next recovery. A sticky status flag records that a brown-out caused a reset.

Top module: `bor_rst_seq`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1 and `bor_flag` is 0 with no clock edge needed. After `por_n` rises, the supply is assumed low until the synchronizer has sampled it.
- R2: A high pulse of N clock cycles on `supply_low_raw`, with detection enabled and `rst_out` at 0, asserts `rst_out` if and only if N > QUAL_CYCLES. A sustained low supply raises `rst_out` on the (3+QUAL_CYCLES)-th rising edge after the raw flag goes high.
- R3: With `bor_mode` = 2'b00, detection is disabled and no supply dip asserts `rst_out`.
- R4: With `bor_mode` = 2'b01, detection is enabled exactly when `sw_bor_en` is 1.
- R5: With `bor_mode` = 2'b10, detection is disabled while `sleep_i` is 1 and enabled while it is 0. `sw_bor_en` has no effect in this mode.
- R6: With `bor_mode` = 2'b11, detection is enabled whatever `sleep_i` and `sw_bor_en` are.
- R7: Once reset is asserted, it stays asserted for as long as an enabled supply-low condition persists.
- R8: With `pwrt_en_n` = 0, `rst_out` falls on the (3+PWRT_CYCLES)-th rising edge after `supply_low_raw` falls. With `pwrt_en_n` = 1, it falls on the 3rd.
- R9: If the supply goes low while the power-up delay runs, reset stays asserted and the full delay restarts after the next recovery, even when the dip is shorter than the qualification time.
- R10: A one-cycle `wdt_rst` pulse asserts `rst_out` at the next edge. With a good supply and `pwrt_en_n` = 0, reset falls PWRT_CYCLES+1 edges after that.
- R11: `bor_flag` is set when a qualified brown-out causes a reset. A watchdog reset does not set it. Only `flag_clr` or power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| supply_low_raw | input | 1 | Raw comparator flag, 1 = supply below threshold |
| bor_mode | input | 2 | Detection policy: 00 off, 01 software, 10 off in sleep, 11 on |
| sw_bor_en | input | 1 | Software detection enable, used in mode 01 |
| sleep_i | input | 1 | Device is in sleep |
| pwrt_en_n | input | 1 | Power-up delay enable, active low |
| wdt_rst | input | 1 | Watchdog reset request |
| flag_clr | input | 1 | Clears the brown-out status flag |
| rst_out | output | 1 | Internal reset, active high, registered |
| bor_flag | output | 1 | Sticky brown-out status |

## Verification
Every cycle, the assertions check the local cause and effect of the sequencer: a watchdog request or a qualified trip asserts reset at the next edge, and mode 00 never trips. Reset falls only when the supply was good in the previous cycle, and with the delay disabled it falls one cycle after the supply is good. The flag rises only together with reset, and a clear while reset is asserted leaves it low. The bench's sweeps cover what needs whole scenarios: the exact pulse length at which a dip starts to trip, the release latency in cycles with the delay on and off, the restart of the delay after a short dip, and the truth table of the sixteen policy combinations.

// File: rtl/bor_pkg.sv
package bor_pkg;

    typedef enum logic [1:0] {
        BM_OFF      = 2'b00,
        BM_SOFT     = 2'b01,
        BM_SLEEPOFF = 2'b10,
        BM_ON       = 2'b11
    } bor_mode_e;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'b00,
        PH_DELAY = 2'b01,
        PH_RUN   = 2'b10
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   rst;
        logic   flag;
    } seq_t;

    localparam seq_t SEQ_RESET = '{phase: PH_HOLD, rst: 1'b1, flag: 1'b0};

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bor_policy.sv
module bor_policy
    import bor_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sw_en,
    input  logic       sleep,
    output logic       det_en
);
    always_comb begin
        unique case (bor_mode_e'(mode))
            BM_OFF:      det_en = 1'b0;
            BM_SOFT:     det_en = sw_en;
            BM_SLEEPOFF: det_en = ~sleep;
            BM_ON:       det_en = 1'b1;
            default:     det_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/bor_qualify.sv
module bor_qualify #(
    parameter int QUAL_CYCLES = 100
) (
    input  logic clk,
    input  logic arst_n,
    input  logic low,
    output logic trip
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!low)               cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign trip = low && (cnt_q == LIMIT);
endmodule

// File: rtl/bor_delay.sv
module bor_delay #(
    parameter int PWRT_CYCLES = 2048000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clear,
    output logic done
);
    localparam int TW = $clog2(PWRT_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(PWRT_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/bor_rst_seq.sv
module bor_rst_seq
    import bor_pkg::*;
#(
    parameter int QUAL_CYCLES = 100,
    parameter int PWRT_CYCLES = 2048000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_low_raw,
    input  logic [1:0] bor_mode,
    input  logic       sw_bor_en,
    input  logic       sleep_i,
    input  logic       pwrt_en_n,
    input  logic       wdt_rst,
    input  logic       flag_clr,
    output logic       rst_out,
    output logic       bor_flag
);
    logic low_sync;
    logic det_en;
    logic low_hold;
    logic qual_trip;
    logic delay_done;
    logic delay_clr;
    seq_t s_d, s_q;

    bor_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .arst_n(por_n), .d(supply_low_raw), .q(low_sync)
    );

    bor_policy u_policy (
        .mode(bor_mode), .sw_en(sw_bor_en), .sleep(sleep_i), .det_en(det_en)
    );

    assign low_hold = low_sync & det_en;

    bor_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .arst_n(por_n), .low(low_hold), .trip(qual_trip)
    );

    assign delay_clr = (s_q.phase != PH_DELAY);

    bor_delay #(.PWRT_CYCLES(PWRT_CYCLES)) u_delay (
        .clk(clk), .arst_n(por_n), .clear(delay_clr), .done(delay_done)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_HOLD: begin
                if (!low_hold && !wdt_rst)
                    s_d.phase = pwrt_en_n ? PH_RUN : PH_DELAY;
            end
            PH_DELAY: begin
                if (low_hold || wdt_rst)
                    s_d.phase = PH_HOLD;
                else if (delay_done || pwrt_en_n)
                    s_d.phase = PH_RUN;
            end
            PH_RUN: begin
                if (qual_trip || wdt_rst)
                    s_d.phase = PH_HOLD;
            end
            default: s_d.phase = PH_HOLD;
        endcase

        if (flag_clr)
            s_d.flag = 1'b0;
        if (s_q.phase == PH_RUN && qual_trip)
            s_d.flag = 1'b1;

        s_d.rst = (s_d.phase != PH_RUN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    assign rst_out  = s_q.rst;
    assign bor_flag = s_q.flag;
endmodule

// File: rtl/bor_rst_seq_chk.sv
module bor_rst_seq_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_out,
    input logic       bor_flag,
    input logic       flag_clr,
    input logic       wdt_rst,
    input logic [1:0] bor_mode,
    input logic       pwrt_en_n,
    input logic       low_hold,
    input logic       qual_trip
);
    AST_WDT_FORCES_RST: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst |=> rst_out);                                            // R10

    AST_TRIP_FORCES_RST: assert property (@(posedge clk) disable iff (!por_n)
        qual_trip |=> rst_out);                                          // R2

    AST_OFF_NEVER_TRIPS: assert property (@(posedge clk) disable iff (!por_n)
        (bor_mode == 2'b00 && !rst_out && !wdt_rst) |=> !rst_out);       // R3

    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> $past(!low_hold));                            // R7

    AST_NO_DELAY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (rst_out && pwrt_en_n && !low_hold && !wdt_rst) |=> !rst_out);   // R8

    AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bor_flag) |-> rst_out);                                    // R11

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (flag_clr && rst_out) |=> !bor_flag);                            // R11
endmodule

bind bor_rst_seq bor_rst_seq_chk u_chk (
    .clk(clk), .por_n(por_n), .rst_out(rst_out), .bor_flag(bor_flag),
    .flag_clr(flag_clr), .wdt_rst(wdt_rst), .bor_mode(bor_mode),
    .pwrt_en_n(pwrt_en_n), .low_hold(low_hold), .qual_trip(qual_trip)
);

// File: tb/bor_rst_seq_tb.sv
`timescale 1ns/1ps
module bor_rst_seq_tb;
    localparam int Q = 4;
    localparam int P = 10;

    logic       clk = 1'b0;
    logic       por_n, raw, sw_en, sleep, pwrt_n, wdt, clr;
    logic [1:0] mode;
    logic       rst_out, bor_flag;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bor_rst_seq #(.QUAL_CYCLES(Q), .PWRT_CYCLES(P)) u_dut (
        .clk(clk), .por_n(por_n), .supply_low_raw(raw), .bor_mode(mode),
        .sw_bor_en(sw_en), .sleep_i(sleep), .pwrt_en_n(pwrt_n),
        .wdt_rst(wdt), .flag_clr(clr), .rst_out(rst_out), .bor_flag(bor_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_out && n < 500);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < P + Q + 40; i++) begin
            if (!rst_out) break;
            @(negedge clk);
        end
    endtask

    task automatic dip(input int len, output bit tripped);
        tripped = 1'b0;
        raw = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (rst_out) tripped = 1'b1;
        end
        raw = 1'b0;
        for (int i = 0; i < Q + 6; i++) begin
            @(negedge clk);
            if (rst_out) tripped = 1'b1;
        end
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  n;
        bit  t;
        bit  any;
        bit  exp_en;
        string tag;

        por_n = 1'b0; raw = 1'b1; mode = 2'b11; sw_en = 1'b0; sleep = 1'b0;
        pwrt_n = 1'b0; wdt = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        chk(rst_out == 1'b1, "R1 rst in por", rst_out, 1);
        chk(bor_flag == 1'b0, "R1 flag in por", bor_flag, 0);

        por_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rst_out == 1'b1, "R7 held while supply low", rst_out, 1);
        raw = 1'b0;
        wait_release(n);
        chk(n == 3 + P, "R8 power-up release latency", n, 3 + P);

        // R2: sweep dip length across the qualification boundary
        any = 1'b0;
        for (int len = 1; len <= Q + 3; len++) begin
            dip(len, t);
            chk(t == (len > Q), "R2 dip length qualification", t, int'(len > Q));
            if (len > Q) any = 1'b1;
        end
        chk(bor_flag == any, "R11 flag after trips", bor_flag, any);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk(bor_flag == 1'b0, "R11 flag cleared", bor_flag, 0);

        // R3..R6: policy truth table
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    mode = 2'(m); sw_en = s[0]; sleep = sl[0];
                    @(negedge clk);
                    case (m)
                        0: begin exp_en = 1'b0;    tag = "R3 mode off"; end
                        1: begin exp_en = s[0];    tag = "R4 mode soft"; end
                        2: begin exp_en = !sl[0];  tag = "R5 mode sleep-off"; end
                        default: begin exp_en = 1'b1; tag = "R6 mode on"; end
                    endcase
                    dip(Q + 3, t);
                    chk(t == exp_en, tag, t, exp_en);
                end
            end
        end
        chk(bor_flag == 1'b1, "R11 flag after policy sweep", bor_flag, 1);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        mode = 2'b11; sw_en = 1'b0; sleep = 1'b0;

        // R7/R8: long low with delay disabled, then enabled
        pwrt_n = 1'b1;
        raw = 1'b1;
        repeat (Q + 8) @(negedge clk);
        chk(rst_out == 1'b1, "R7 held during long low", rst_out, 1);
        raw = 1'b0;
        wait_release(n);
        chk(n == 3, "R8 release without delay", n, 3);
        pwrt_n = 1'b0;
        raw = 1'b1;
        repeat (Q + 8) @(negedge clk);
        raw = 1'b0;
        wait_release(n);
        chk(n == 3 + P, "R8 release with delay", n, 3 + P);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;

        // R10: watchdog reset
        wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        chk(rst_out == 1'b1, "R10 wdt asserts reset", rst_out, 1);
        chk(bor_flag == 1'b0, "R11 wdt leaves flag", bor_flag, 0);
        wait_release(n);
        chk(n == P + 1, "R10 wdt release latency", n, P + 1);

        // R9: short dip during delay restarts it
        wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        repeat (3) @(negedge clk);
        raw = 1'b1;
        repeat (2) @(negedge clk);
        chk(rst_out == 1'b1, "R9 still held", rst_out, 1);
        raw = 1'b0;
        wait_release(n);
        chk(n == 3 + P, "R9 delay restarted", n, 3 + P);
        chk(bor_flag == 1'b0, "R11 short dip no flag", bor_flag, 0);

        // R1: power-on reset clears flag asynchronously
        dip(Q + 3, t);
        chk(bor_flag == 1'b1, "R11 flag set by trip", bor_flag, 1);
        @(negedge clk);
        #1 por_n = 1'b0;
        #0.5;
        chk(bor_flag == 1'b0, "R1 por clears flag", bor_flag, 0);
        chk(rst_out == 1'b1, "R1 por asserts reset", rst_out, 1);
        @(negedge clk) por_n = 1'b1;
        wait_release(n);
        chk(n == 3 + P, "R1 sync assumes low after por", n, 3 + P);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule